// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block caches recent virtual-to-physical page translations for a paged memory system with 1 KB pages. A lookup request presents a virtual address, an address-space identifier and a read/write flag. In the same cycle, the block compares the request against every stored entry in parallel. It returns the translated physical address, a hit flag, a protection-fault flag, and the status bits of the matching entry. The low ten address bits skip translation, so a downstream cache can start indexing from them before the match result settles.

Each entry holds a virtual page number, a physical page number, an address-space tag, a valid bit, a referenced bit, a dirty bit, and a permission of read-only or read/write. A lookup that hits and is permitted updates that entry's usage bits at the next clock edge. A write that hits a read-only page only reports a fault. A miss is only reported: walking the page table is left to an external agent, which installs the result through the refill port. The same port is also used by software. Entries can be invalidated all at once, or only those belonging to one address space.

Top module: `tlb_fa`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, so every lookup misses.
- R2: A lookup hits only when an entry is valid and both its virtual page number (address bits above bit 9) and its address-space tag equal the request. At most one entry matches.
- R3: `lk_paddr` bits 9:0 always equal `lk_vaddr` bits 9:0. On a hit, the upper bits are the entry's physical page number. On a miss, the upper bits are zero.
- R4: On a hit, `lk_dirty`, `lk_ref` and `lk_writable` show the matched entry's state as it was before this access.
- R5: After a permitted read hit, the referenced bit is set from the next cycle on. A permitted write hit also sets the dirty bit.
- R6: A write that hits an entry whose permission is read-only (`rf_writable`=0 at refill) raises `lk_fault` with `lk_hit`=1. It leaves the referenced bit, the dirty bit and the valid bit of every entry unchanged.
- R7: A refill whose page and tag match no valid entry goes into the lowest-numbered invalid slot, if one exists.
- R8: When no slot is invalid, a refill replaces the slot named by a rotating pointer. The pointer is 0 after reset and advances by one, modulo the depth, on each such replacement.
- R9: A refill whose page and tag equal a valid entry overwrites that entry in place. No duplicate is created.
- R10: A refill clears the installed entry's referenced and dirty bits.
- R11: `fl_all` invalidates every entry. `fl_by_asid` invalidates only entries whose tag equals `fl_asid`.
- R12: With `lk_valid` low, `lk_hit` and `lk_fault` are low and no entry state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address space of the request |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_paddr | output | PA_W | Translated physical address |
| lk_hit | output | 1 | A matching entry was found |
| lk_fault | output | 1 | Write to a read-only page |
| lk_dirty | output | 1 | Matched entry's dirty bit |
| lk_ref | output | 1 | Matched entry's referenced bit |
| lk_writable | output | 1 | Matched entry allows writes |
| rf_valid | input | 1 | Install an entry |
| rf_vpn | input | VA_W-10 | Virtual page number to install |
| rf_asid | input | ASID_W | Address-space tag to install |
| rf_ppn | input | PA_W-10 | Physical page number to install |
| rf_writable | input | 1 | 1 = read/write, 0 = read-only |
| fl_all | input | 1 | Invalidate every entry |
| fl_by_asid | input | 1 | Invalidate entries of one address space |
| fl_asid | input | ASID_W | Address space to invalidate |

## Verification
The hardest state to reach from the ports is a full buffer in which the rotating pointer and the first-invalid search disagree. That state needs all slots filled, one slot freed by a tag-selective flush, and the pointer already moved away from zero. The directed sequence builds exactly this case. It fills every slot with one tag used only once, forces two pointer-based evictions, flushes that single tag, and then shows that the next refill takes the freed slot and the one after that takes the pointer slot. Random traffic over a narrow page and tag space then produces frequent in-place overwrites, selective flushes and read-only write faults, and each one is checked against a bench model of the entries and the pointer.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer.
// Assumes: page offset width is fixed by the top-level parameter.
package tlb_pkg;

    // Entry permission encoding.
    typedef enum logic {
        PERM_RO = 1'b0,
        PERM_RW = 1'b1
    } perm_e;

    // Access kind carried by a lookup.
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

endpackage

// File: rtl/tlb_match.sv
// Parallel comparator bank: flags every valid entry whose page number and
// address-space tag both equal the request.
// Assumes: the caller keeps entries unique, so the result is one-hot or zero.
module tlb_match #(
    parameter int unsigned N      = 8,
    parameter int unsigned VPN_W  = 22,
    parameter int unsigned ASID_W = 8
) (
    input  logic                        req_en,
    input  logic [VPN_W-1:0]            req_vpn,
    input  logic [ASID_W-1:0]           req_asid,
    input  logic [N-1:0]                ent_valid,
    input  logic [N-1:0][VPN_W-1:0]     ent_vpn,
    input  logic [N-1:0][ASID_W-1:0]    ent_asid,
    output logic [N-1:0]                match
);

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = req_en && ent_valid[g] &&
                          (ent_vpn[g] == req_vpn) &&
                          (ent_asid[g] == req_asid);
    end

endmodule

// File: rtl/tlb_select.sv
// One-hot read multiplexer: returns the field word of the selected entry.
// Assumes: sel is one-hot or zero; a zero select returns all zeros.
module tlb_select #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 25
) (
    input  logic [N-1:0]          sel,
    input  logic [N-1:0][W-1:0]   words,
    output logic [W-1:0]          out
);

    // AND-OR reduction across entries.
    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            out = out | (words[i] & {W{sel[i]}});
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Slot chooser for a new entry: the lowest invalid slot when one exists,
// otherwise the slot named by the rotating pointer.
// Assumes: N >= 2 and ptr < N.
module tlb_victim #(
    parameter int unsigned N     = 8,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]      ent_valid,
    input  logic [IDX_W-1:0]  ptr,
    output logic [N-1:0]      slot,
    output logic              use_ptr
);

    logic [N-1:0] free_first;
    logic         any_free;

    // Priority search for the lowest invalid slot.
    always_comb begin
        free_first = '0;
        any_free   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_first = '0;
                free_first[i] = 1'b1;
                any_free = 1'b1;
            end
        end
    end

    // Fall back to the decoded pointer when nothing is free.
    always_comb begin
        use_ptr = !any_free;
        if (any_free) begin
            slot = free_first;
        end else begin
            for (int i = 0; i < N; i++) begin
                slot[i] = (IDX_W'(i) == ptr);
            end
        end
    end

endmodule

// File: rtl/tlb_fa.sv
// Fully associative translation buffer with address-space tags, usage bits
// and read-only protection. The lookup result is combinational; state
// updates (usage bits, refill, flush) take effect at the next clock edge.
// Assumes: 1 KB pages by default, one refill per cycle, and a refill
// overriding a flush or usage update for its own slot in the same cycle.
module tlb_fa #(
    parameter int unsigned ENTRIES   = 8,
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned ASID_W    = 8,
    parameter int unsigned PAGE_BITS = 10,
    localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
    localparam int unsigned PPN_W    = PA_W - PAGE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic               lk_write,
    output logic [PA_W-1:0]    lk_paddr,
    output logic               lk_hit,
    output logic               lk_fault,
    output logic               lk_dirty,
    output logic               lk_ref,
    output logic               lk_writable,
    input  logic               rf_valid,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic [ASID_W-1:0]  rf_asid,
    input  logic [PPN_W-1:0]   rf_ppn,
    input  logic               rf_writable,
    input  logic               fl_all,
    input  logic               fl_by_asid,
    input  logic [ASID_W-1:0]  fl_asid
);
    import tlb_pkg::*;

    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned SEL_W = PPN_W + 3;

    // Entry storage.
    logic [ENTRIES-1:0]              valid_q;
    logic [ENTRIES-1:0]              dirty_q;
    logic [ENTRIES-1:0]              ref_q;
    perm_e [ENTRIES-1:0]             perm_q;
    logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;
    logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
    logic [IDX_W-1:0]                rr_ptr_q;

    // Lookup datapath.
    logic [ENTRIES-1:0]              hit_vec;
    logic [ENTRIES-1:0][SEL_W-1:0]   sel_words;
    logic [SEL_W-1:0]                sel_out;
    logic [PPN_W-1:0]                hit_ppn;
    logic                            hit_rw;
    logic                            lk_ok;
    acc_e                            lk_kind;

    // Refill datapath.
    logic [ENTRIES-1:0]              rf_match;
    logic [ENTRIES-1:0]              vic_slot;
    logic                            vic_use_ptr;
    logic [ENTRIES-1:0]              rf_slot;
    logic                            rf_in_place;
    logic [ENTRIES-1:0]              fl_vec;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .req_en    (lk_valid),
        .req_vpn   (lk_vaddr[VA_W-1:PAGE_BITS]),
        .req_asid  (lk_asid),
        .ent_valid (valid_q),
        .ent_vpn   (vpn_q),
        .ent_asid  (asid_q),
        .match     (hit_vec)
    );

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
        .req_en    (rf_valid),
        .req_vpn   (rf_vpn),
        .req_asid  (rf_asid),
        .ent_valid (valid_q),
        .ent_vpn   (vpn_q),
        .ent_asid  (asid_q),
        .match     (rf_match)
    );

    // Pack per-entry fields returned on a hit.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_pack
        assign sel_words[g] = {perm_q[g] == PERM_RW, dirty_q[g], ref_q[g], ppn_q[g]};
    end

    tlb_select #(.N(ENTRIES), .W(SEL_W)) u_select (
        .sel   (hit_vec),
        .words (sel_words),
        .out   (sel_out)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .ent_valid (valid_q),
        .ptr       (rr_ptr_q),
        .slot      (vic_slot),
        .use_ptr   (vic_use_ptr)
    );

    // Decode the lookup result and protection check.
    always_comb begin
        hit_ppn     = sel_out[PPN_W-1:0];
        lk_ref      = sel_out[PPN_W];
        lk_dirty    = sel_out[PPN_W+1];
        hit_rw      = sel_out[PPN_W+2];
        lk_writable = hit_rw;
        lk_kind     = acc_e'(lk_write);
        lk_hit      = |hit_vec;
        lk_fault    = lk_hit && (lk_kind == ACC_WRITE) && !hit_rw;
        lk_ok       = lk_hit && !lk_fault;
        lk_paddr    = {(lk_hit ? hit_ppn : {PPN_W{1'b0}}), lk_vaddr[PAGE_BITS-1:0]};
    end

    // Choose the refill slot and the flush set.
    always_comb begin
        rf_in_place = |rf_match;
        rf_slot     = rf_valid ? (rf_in_place ? rf_match : vic_slot) : '0;
        for (int i = 0; i < ENTRIES; i++) begin
            fl_vec[i] = fl_all || (fl_by_asid && (asid_q[i] == fl_asid));
        end
    end

    // Per-entry state update: flush, usage bits, then refill on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ref_q   <= '0;
            perm_q  <= {ENTRIES{PERM_RO}};
            vpn_q   <= '0;
            ppn_q   <= '0;
            asid_q  <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fl_vec[i]) begin
                    valid_q[i] <= 1'b0;
                end
                if (lk_ok && hit_vec[i]) begin
                    ref_q[i] <= 1'b1;
                    if (lk_kind == ACC_WRITE) begin
                        dirty_q[i] <= 1'b1;
                    end
                end
                if (rf_slot[i]) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= 1'b0;
                    ref_q[i]   <= 1'b0;
                    perm_q[i]  <= rf_writable ? PERM_RW : PERM_RO;
                    vpn_q[i]   <= rf_vpn;
                    ppn_q[i]   <= rf_ppn;
                    asid_q[i]  <= rf_asid;
                end
            end
        end
    end

    // Rotating replacement pointer, advanced only when it picked the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q <= '0;
        end else if (rf_valid && !rf_in_place && vic_use_ptr) begin
            rr_ptr_q <= (rr_ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
// Assertion checker for the translation buffer, attached by bind.
// Assumes: hit_vec, valid_q, dirty_q and ref_q are the top's internal vectors.
module tlb_fa_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_valid,
    input logic         lk_write,
    input logic         lk_hit,
    input logic         lk_fault,
    input logic         rf_valid,
    input logic         fl_all,
    input logic         fl_by_asid,
    input logic [N-1:0] hit_vec,
    input logic [N-1:0] valid_q,
    input logic [N-1:0] dirty_q,
    input logic [N-1:0] ref_q
);

    // R1: reset leaves no valid entry.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    // R2: never more than one matching entry.
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5: a permitted write hit leaves the matched entry dirty.
    p_dirty_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && !lk_fault && !rf_valid)
        |=> ((dirty_q & $past(hit_vec)) == $past(hit_vec)));

    // R6: a fault implies a write hit.
    p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && lk_write));

    // R6: a fault changes no entry state.
    p_fault_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && !rf_valid && !fl_all && !fl_by_asid)
        |=> ($stable(valid_q) && $stable(dirty_q) && $stable(ref_q)));

    // R11: a full flush empties the buffer.
    p_flush_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_all && !rf_valid) |=> (valid_q == '0));

    // R12: no result without a request.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_fault));

endmodule

bind tlb_fa tlb_fa_chk #(.N(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_write   (lk_write),
    .lk_hit     (lk_hit),
    .lk_fault   (lk_fault),
    .rf_valid   (rf_valid),
    .fl_all     (fl_all),
    .fl_by_asid (fl_by_asid),
    .hit_vec    (hit_vec),
    .valid_q    (valid_q),
    .dirty_q    (dirty_q),
    .ref_q      (ref_q)
);

// File: tb/tlb_fa_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a behavioural model of entries and pointer.
module tlb_fa_tb;
    localparam int N     = 8;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int AS_W  = 8;
    localparam int PB    = 10;
    localparam int VPN_W = VA_W - PB;
    localparam int PPN_W = PA_W - PB;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lk_valid, lk_write;
    logic [VA_W-1:0]   lk_vaddr;
    logic [AS_W-1:0]   lk_asid;
    logic [PA_W-1:0]   lk_paddr;
    logic              lk_hit, lk_fault, lk_dirty, lk_ref, lk_writable;
    logic              rf_valid, rf_writable;
    logic [VPN_W-1:0]  rf_vpn;
    logic [AS_W-1:0]   rf_asid;
    logic [PPN_W-1:0]  rf_ppn;
    logic              fl_all, fl_by_asid;
    logic [AS_W-1:0]   fl_asid;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    // Model state.
    bit               m_v [N];
    bit               m_d [N];
    bit               m_r [N];
    bit               m_w [N];
    logic [VPN_W-1:0] m_vpn [N];
    logic [PPN_W-1:0] m_ppn [N];
    logic [AS_W-1:0]  m_as [N];
    int               m_ptr;

    always #5 clk = ~clk;

    tlb_fa u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
        .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_fault(lk_fault),
        .lk_dirty(lk_dirty), .lk_ref(lk_ref), .lk_writable(lk_writable),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_ppn(rf_ppn),
        .rf_writable(rf_writable),
        .fl_all(fl_all), .fl_by_asid(fl_by_asid), .fl_asid(fl_asid)
    );

    function automatic int find(logic [VPN_W-1:0] vpn, logic [AS_W-1:0] as);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_as[i] == as) return i;
        return -1;
    endfunction

    function automatic int pick_slot(logic [VPN_W-1:0] vpn, logic [AS_W-1:0] as);
        int k = find(vpn, as);
        if (k >= 0) return k;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return -2;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; lk_write = 0; lk_vaddr = '0; lk_asid = '0;
        rf_valid = 0; rf_writable = 0; rf_vpn = '0; rf_asid = '0; rf_ppn = '0;
        fl_all = 0; fl_by_asid = 0; fl_asid = '0;
    endtask

    // Lookup with model-based checks; dir_hit = -1 means no directed expectation.
    task automatic do_lookup(logic [VPN_W-1:0] vpn, logic [AS_W-1:0] as, bit wr,
                             bit req, int dir_hit, string tag);
        logic [PB-1:0]   off = PB'($urandom);
        int              k   = req ? find(vpn, as) : -1;
        bit              eh  = (k >= 0);
        bit              ef  = eh && wr && !m_w[k < 0 ? 0 : k];
        logic [PA_W-1:0] ep  = {(eh ? m_ppn[k] : {PPN_W{1'b0}}), off};
        @(negedge clk);
        lk_valid = req; lk_write = wr; lk_asid = as; lk_vaddr = {vpn, off};
        #2;
        check(lk_hit == eh, {tag, " R2 hit"}, 64'(lk_hit), 64'(eh));
        check(lk_fault == ef, {tag, " R6 fault"}, 64'(lk_fault), 64'(ef));
        check(lk_paddr == ep, {tag, " R3 paddr"}, 64'(lk_paddr), 64'(ep));
        if (dir_hit >= 0)
            check(lk_hit == dir_hit[0], {tag, " directed hit"}, 64'(lk_hit), 64'(dir_hit));
        if (eh) begin
            check({lk_dirty, lk_ref, lk_writable} == {m_d[k], m_r[k], m_w[k]},
                  {tag, " R4 status"}, 64'({lk_dirty, lk_ref, lk_writable}),
                  64'({m_d[k], m_r[k], m_w[k]}));
            if (!ef) begin
                m_r[k] = 1;
                if (wr) m_d[k] = 1;
            end
        end
        @(posedge clk); #1;
        idle();
    endtask

    task automatic do_refill(logic [VPN_W-1:0] vpn, logic [AS_W-1:0] as,
                             logic [PPN_W-1:0] ppn, bit w);
        int s = pick_slot(vpn, as);
        if (s == -2) begin
            s = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        @(negedge clk);
        rf_valid = 1; rf_vpn = vpn; rf_asid = as; rf_ppn = ppn; rf_writable = w;
        @(posedge clk); #1;
        m_v[s] = 1; m_d[s] = 0; m_r[s] = 0; m_w[s] = w;
        m_vpn[s] = vpn; m_ppn[s] = ppn; m_as[s] = as;
        idle();
    endtask

    task automatic do_flush(bit all, logic [AS_W-1:0] as);
        @(negedge clk);
        fl_all = all; fl_by_asid = !all; fl_asid = as;
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) if (all || m_as[i] == as) m_v[i] = 0;
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        rst_n = 0;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0;
            m_vpn[i] = '0; m_ppn[i] = '0; m_as[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: empty after reset; R3 offset passes on a miss.
        do_lookup(22'h0, 8'h0, 0, 1, 0, "R1 empty");
        // R2, R4, R5, R10: basic fill and usage bits.
        do_refill(22'h5, 8'h1, 22'h2A, 1);
        do_lookup(22'h5, 8'h1, 0, 1, 1, "R10 fresh");
        do_lookup(22'h5, 8'h2, 0, 1, 0, "R2 other tag");
        do_lookup(22'h5, 8'h1, 1, 1, 1, "R5 ref then write");
        do_lookup(22'h5, 8'h1, 0, 1, 1, "R5 dirty seen");
        // R6: write to read-only faults and freezes state.
        do_refill(22'h7, 8'h1, 22'h33, 0);
        do_lookup(22'h7, 8'h1, 1, 1, 1, "R6 fault");
        do_lookup(22'h7, 8'h1, 0, 1, 1, "R6 no ref change");
        // R12: idle request has no effect.
        do_refill(22'h9, 8'h1, 22'h44, 1);
        do_lookup(22'h9, 8'h1, 1, 0, 0, "R12 idle");
        do_lookup(22'h9, 8'h1, 0, 1, 1, "R12 state unchanged");
        // R9: in-place overwrite clears status.
        do_refill(22'h5, 8'h1, 22'h3FF, 0);
        do_lookup(22'h5, 8'h1, 0, 1, 1, "R9 overwrite");
        // R11: selective and full flush.
        do_refill(22'h3, 8'h2, 22'h55, 1);
        do_flush(0, 8'h1);
        do_lookup(22'h5, 8'h1, 0, 1, 0, "R11 tag flushed");
        do_lookup(22'h3, 8'h2, 0, 1, 1, "R11 other tag kept");
        do_flush(1, 8'h0);
        do_lookup(22'h3, 8'h2, 0, 1, 0, "R11 all flushed");
        // R7, R8: full buffer, pointer eviction, free-slot preference.
        for (int i = 0; i < N; i++)
            do_refill(22'(100 + i), (i == 3) ? 8'h3 : 8'h0, 22'(500 + i), 1);
        do_refill(22'd200, 8'h0, 22'd600, 1);
        do_lookup(22'd100, 8'h0, 0, 1, 0, "R8 slot0 evicted");
        do_lookup(22'd101, 8'h0, 0, 1, 1, "R8 slot1 kept");
        do_refill(22'd201, 8'h0, 22'd601, 1);
        do_lookup(22'd101, 8'h0, 0, 1, 0, "R8 pointer advanced");
        do_flush(0, 8'h3);
        do_refill(22'd202, 8'h0, 22'd602, 1);
        do_lookup(22'd102, 8'h0, 0, 1, 1, "R7 free slot used");
        do_refill(22'd203, 8'h0, 22'd603, 1);
        do_lookup(22'd102, 8'h0, 0, 1, 0, "R8 pointer slot used");

        // Random traffic over a narrow page/tag space.
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(0, 99);
            logic [VPN_W-1:0] v = VPN_W'($urandom_range(0, 15));
            logic [AS_W-1:0]  a = AS_W'($urandom_range(0, 3));
            if (op < 60)
                do_lookup(v, a, $urandom_range(0, 1) == 1, $urandom_range(0, 9) != 0, -1, "rand");
            else if (op < 92)
                do_refill(v, a, PPN_W'($urandom), $urandom_range(0, 2) != 0);
            else if (op < 98)
                do_flush(0, a);
            else
                do_flush(1, 8'h0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule